// File: doc/BRIEF.md
# Code-Protect Verify and Lock Controller

This block stands between an on-chip program memory and the port that reads it back for verification. It keeps a 32-byte scrambling key that the programming interface writes. On a verify read it returns the code byte XNORed with the key byte chosen by the read address, so the key bytes are applied in a fixed cyclic order. Anyone reading the code back without the key therefore sees scrambled data. An erased key byte holds 0xFF, and XNOR with 0xFF returns the code byte unchanged.

Two one-time lock bits set how much protection is in force. They are decoded into three permission flags: blocking internal memory access by code fetched from outside, inhibiting further programming, and inhibiting verification. The lock bits and the key model non-volatile cells. The ordinary reset leaves them alone and only a whole-array erase clears them. While lock bit 1 is programmed, the external-code-select pin is sampled and held during reset. After reset, any difference between the held level and the live pin level raises a mismatch flag.

Top module: `cpl_guard`

## Requirements
- R1: While `erase_n` is low at a clock edge, every key byte is set to 0xFF, both lock bits return to unprogrammed and the held select level is cleared. After an erase, all three permission flags are 0 and a verify read returns the code byte unchanged.
- R2: A verify request (`vfy_req` high at a clock edge) with verification allowed gives `vfy_valid` high on the next cycle, and `vfy_data` then equals `~(code_rdata ^ key[idx])`. `idx` is the verify address modulo 32. In the cycle with no request, `vfy_valid` is low.
- R3: The key sequence wraps. Address 32 uses key byte 0, address 31 uses key byte 31, and address 0x1FE3 uses key byte 3.
- R4: A key write (`key_wr_en` high at a clock edge, index `key_wr_idx`) stores `key_wr_data` while programming is allowed. Later verify reads at that index use the new byte.
- R5: The lock-bit state is {bit2, bit1}, and a set bit means programmed. `lock1_set` and `lock2_set` program the bits and can never clear them. State 00 gives no restrictions. State 01 raises `ext_fetch_block` and `prog_inhibit`. State 11 also raises `vfy_inhibit`.
- R6: The reserved state 10 (only bit 2 programmed) acts like state 00. All flags are 0, key writes take effect and verification works.
- R7: While `prog_inhibit` is high, key writes are ignored. Verify reads keep using the key bytes stored before the inhibit.
- R8: While `vfy_inhibit` is high, `code_rd_en` stays low, and a verify request gives `vfy_valid` high with `vfy_data` = 0xFF on the next cycle.
- R9: A low `rst_n` does not change the lock bits or the key bytes.
- R10: While lock bit 1 is programmed, each clock edge with `rst_n` low captures `ext_sel_pin`. After reset, `ext_sel_mismatch` is high exactly when the live pin differs from the captured level. It is 0 during reset and whenever lock bit 1 is unprogrammed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the verify path; select-pin capture window |
| erase_n | input | 1 | Synchronous active-low whole-array erase of keys and lock bits |
| key_wr_en | input | 1 | Key byte write strobe |
| key_wr_idx | input | 5 | Key byte index to write |
| key_wr_data | input | 8 | Key byte value |
| lock1_set | input | 1 | Program lock bit 1 |
| lock2_set | input | 1 | Program lock bit 2 |
| ext_sel_pin | input | 1 | Live level of the external-code-select pin |
| vfy_req | input | 1 | Verify read request |
| vfy_addr | input | 16 | Verify read address |
| code_rdata | input | 8 | Code byte from program memory for the current request |
| code_rd_en | output | 1 | Read enable to program memory for a permitted verify |
| vfy_valid | output | 1 | Verify data valid, one cycle after the request |
| vfy_data | output | 8 | Scrambled code byte, or 0xFF when verification is inhibited |
| ext_fetch_block | output | 1 | Externally fetched code may not read internal memory |
| prog_inhibit | output | 1 | Further programming disabled |
| vfy_inhibit | output | 1 | Program verification disabled |
| ext_sel_mismatch | output | 1 | Captured select level differs from live pin while lock bit 1 is set |

## Verification
The bench aims at the key index. It reads at 31, 32 and a high address whose low five bits select byte 3. An index taken from too many or too few address bits would pick the wrong key there. It runs the reserved lock state with a key write and a verify read, because a decoder that treats any programmed bit as a lock would block them. It tries a key write after lock bit 1 and then reads back through verify, which exposes a store that still accepts writes. It pulses reset with both lock bits set to show the locks survive. It drives the select pin against the captured level and also toggles the pin with the lock clear. A latch that ignores lock bit 1, or a flag that is not masked during reset, gives the wrong mismatch output in those cases.

// File: rtl/cpl_pkg.sv
// Package: shared parameters and the lock-state encoding for the
// code-protect controller. Assumes lock bit 1 is the low bit of the code.
package cpl_pkg;
    localparam int DATA_W  = 8;
    localparam int KEY_N   = 32;
    localparam int ADDR_W  = 16;

    // Lock state {bit2, bit1}; a 1 means the bit is programmed.
    typedef enum logic [1:0] {
        LK_OPEN  = 2'b00,
        LK_NOEXT = 2'b01,
        LK_RSVD  = 2'b10,
        LK_FULL  = 2'b11
    } lock_mode_e;

    typedef struct packed {
        logic ext_block;
        logic prog_inh;
        logic vfy_inh;
    } lock_perm_t;
endpackage

// File: rtl/cpl_key_store.sv
// Key store: KEY_N bytes of modelled non-volatile key cells.
// The erase sets every byte to all ones. Writes land only when wr_en is high.
// The caller does the gating for programming inhibit.
// The read is combinational. With rd_en low, no entry is selected and
// the port returns all ones.
module cpl_key_store #(
    parameter int KEY_N  = 32,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(KEY_N)
) (
    input  logic              clk,
    input  logic              erase_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] key_q [KEY_N];

    for (genvar g = 0; g < KEY_N; g++) begin : g_cell
        // Purpose: one key cell, erased to ones, written when its index hits.
        always_ff @(posedge clk) begin
            if (!erase_n)
                key_q[g] <= '1;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                key_q[g] <= wr_data;
        end
    end

    // Purpose: the selected byte, or all ones when no read is enabled.
    always_comb begin
        rd_data = '1;
        if (rd_en)
            rd_data = key_q[rd_idx];
    end
endmodule

// File: rtl/cpl_lock_bits.sv
// Lock bits: two one-time cells. A set strobe programs a bit, and only the
// erase clears it. The state is decoded into the three permission flags.
// The reserved state grants the same rights as the open state.
module cpl_lock_bits
    import cpl_pkg::*;
(
    input  logic       clk,
    input  logic       erase_n,
    input  logic       set1,
    input  logic       set2,
    output logic       lock1,
    output lock_perm_t perm
);
    logic       bit1_q, bit2_q;
    lock_mode_e mode;

    // Purpose: one-time programming of both lock cells.
    always_ff @(posedge clk) begin
        if (!erase_n) begin
            bit1_q <= 1'b0;
            bit2_q <= 1'b0;
        end else begin
            if (set1) bit1_q <= 1'b1;
            if (set2) bit2_q <= 1'b1;
        end
    end

    assign mode  = lock_mode_e'({bit2_q, bit1_q});
    assign lock1 = bit1_q;

    // Purpose: decode the lock state into permission flags.
    always_comb begin
        perm = '0;
        unique case (mode)
            LK_OPEN, LK_RSVD: perm = '0;
            LK_NOEXT: begin
                perm.ext_block = 1'b1;
                perm.prog_inh  = 1'b1;
            end
            LK_FULL: begin
                perm.ext_block = 1'b1;
                perm.prog_inh  = 1'b1;
                perm.vfy_inh   = 1'b1;
            end
            default: perm = '0;
        endcase
    end
endmodule

// File: rtl/cpl_sel_latch.sv
// Select-pin latch: while lock bit 1 is programmed it captures the pin
// on every clock edge in reset. After reset it compares the captured
// level with the live one. The flag stays low in reset and while lock bit 1
// is clear.
module cpl_sel_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic erase_n,
    input  logic lock1,
    input  logic pin,
    output logic mismatch
);
    logic held_q;

    // Purpose: capture the pin during reset when the lock asks for it.
    always_ff @(posedge clk) begin
        if (!erase_n)
            held_q <= 1'b0;
        else if (!rst_n && lock1)
            held_q <= pin;
    end

    // Purpose: flag disagreement between held and live level.
    assign mismatch = lock1 && rst_n && (held_q != pin);
endmodule

// File: rtl/cpl_verify_path.sv
// Verify path: turns a verify request into a key index, then registers
// the scrambled byte one cycle later. Assumes code_rdata is valid in the
// same cycle as the request. While verification is inhibited, no read
// goes to memory or the key store, and the result is all ones.
module cpl_verify_path #(
    parameter int KEY_N  = 32,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16,
    localparam int IDX_W = $clog2(KEY_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] code,
    input  logic              inhibit,
    input  logic [DATA_W-1:0] key_byte,
    output logic [IDX_W-1:0]  key_idx,
    output logic              rd_en,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] scrambled;

    assign key_idx   = IDX_W'(addr % ADDR_W'(KEY_N));
    assign rd_en     = req && !inhibit;
    assign scrambled = inhibit ? '1 : ~(code ^ key_byte);

    // Purpose: register the verify result and its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '1;
        end else begin
            valid <= req;
            if (req)
                data <= scrambled;
        end
    end
endmodule

// File: rtl/cpl_guard.sv
// Top: code-protect verify and lock controller. Connects the key store,
// the lock cells, the select-pin latch and the verify path. Key writes
// are gated by the programming inhibit. Lock bits stay programmable so
// that the full lock can follow the partial one.
module cpl_guard
    import cpl_pkg::*;
#(
    parameter int P_KEY_N  = KEY_N,
    parameter int P_DATA_W = DATA_W,
    parameter int P_ADDR_W = ADDR_W,
    localparam int IDX_W   = $clog2(P_KEY_N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                erase_n,
    input  logic                key_wr_en,
    input  logic [IDX_W-1:0]    key_wr_idx,
    input  logic [P_DATA_W-1:0] key_wr_data,
    input  logic                lock1_set,
    input  logic                lock2_set,
    input  logic                ext_sel_pin,
    input  logic                vfy_req,
    input  logic [P_ADDR_W-1:0] vfy_addr,
    input  logic [P_DATA_W-1:0] code_rdata,
    output logic                code_rd_en,
    output logic                vfy_valid,
    output logic [P_DATA_W-1:0] vfy_data,
    output logic                ext_fetch_block,
    output logic                prog_inhibit,
    output logic                vfy_inhibit,
    output logic                ext_sel_mismatch
);
    lock_perm_t          perm;
    logic                lock1;
    logic                key_rd_en;
    logic [IDX_W-1:0]    key_idx;
    logic [P_DATA_W-1:0] key_byte;
    logic                key_we_gated;

    assign key_we_gated = key_wr_en && !perm.prog_inh;

    cpl_lock_bits u_lock (
        .clk     (clk),
        .erase_n (erase_n),
        .set1    (lock1_set),
        .set2    (lock2_set),
        .lock1   (lock1),
        .perm    (perm)
    );

    cpl_key_store #(.KEY_N(P_KEY_N), .DATA_W(P_DATA_W)) u_keys (
        .clk     (clk),
        .erase_n (erase_n),
        .wr_en   (key_we_gated),
        .wr_idx  (key_wr_idx),
        .wr_data (key_wr_data),
        .rd_en   (key_rd_en),
        .rd_idx  (key_idx),
        .rd_data (key_byte)
    );

    cpl_sel_latch u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .erase_n  (erase_n),
        .lock1    (lock1),
        .pin      (ext_sel_pin),
        .mismatch (ext_sel_mismatch)
    );

    cpl_verify_path #(.KEY_N(P_KEY_N), .DATA_W(P_DATA_W), .ADDR_W(P_ADDR_W)) u_vfy (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (vfy_req),
        .addr     (vfy_addr),
        .code     (code_rdata),
        .inhibit  (perm.vfy_inh),
        .key_byte (key_byte),
        .key_idx  (key_idx),
        .rd_en    (key_rd_en),
        .valid    (vfy_valid),
        .data     (vfy_data)
    );

    assign code_rd_en      = key_rd_en;
    assign ext_fetch_block = perm.ext_block;
    assign prog_inhibit    = perm.prog_inh;
    assign vfy_inhibit     = perm.vfy_inh;
endmodule

// File: rtl/cpl_guard_checker.sv
// Checker: temporal properties over the ports of cpl_guard, attached by bind.
module cpl_guard_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              erase_n,
    input logic              vfy_req,
    input logic              code_rd_en,
    input logic              vfy_valid,
    input logic [DATA_W-1:0] vfy_data,
    input logic              ext_fetch_block,
    input logic              prog_inhibit,
    input logic              vfy_inhibit,
    input logic              ext_sel_mismatch
);
    // R2: every request yields a valid strobe on the next cycle.
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vfy_req |=> vfy_valid);

    // R8: no memory read while verification is inhibited.
    assert_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n || !erase_n)
        vfy_inhibit |-> !code_rd_en);

    // R8: an inhibited request returns all ones.
    assert_blank_data_R8: assert property (@(posedge clk) disable iff (!rst_n || !erase_n)
        (vfy_req && vfy_inhibit) |=> (vfy_data == '1));

    // R5: the verify inhibit comes only on top of the other two restrictions.
    assert_lock_order_R5: assert property (@(posedge clk) disable iff (!rst_n || !erase_n)
        vfy_inhibit |-> (prog_inhibit && ext_fetch_block));

    // R9: once programming is inhibited it stays so until an erase.
    assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!erase_n)
        prog_inhibit |=> (prog_inhibit || !erase_n));

    // R10: the mismatch flag needs lock bit 1 in force.
    assert_mismatch_locked_R10: assert property (@(posedge clk) disable iff (!rst_n || !erase_n)
        ext_sel_mismatch |-> ext_fetch_block);
endmodule

bind cpl_guard cpl_guard_checker #(.DATA_W(P_DATA_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .erase_n          (erase_n),
    .vfy_req          (vfy_req),
    .code_rd_en       (code_rd_en),
    .vfy_valid        (vfy_valid),
    .vfy_data         (vfy_data),
    .ext_fetch_block  (ext_fetch_block),
    .prog_inhibit     (prog_inhibit),
    .vfy_inhibit      (vfy_inhibit),
    .ext_sel_mismatch (ext_sel_mismatch)
);

// File: tb/cpl_guard_tb.sv
// Directed bench for cpl_guard: one task per scenario, each checking itself.
module cpl_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        erase_n = 1'b0;
    logic        key_wr_en = 1'b0;
    logic [4:0]  key_wr_idx = '0;
    logic [7:0]  key_wr_data = '0;
    logic        lock1_set = 1'b0;
    logic        lock2_set = 1'b0;
    logic        ext_sel_pin = 1'b0;
    logic        vfy_req = 1'b0;
    logic [15:0] vfy_addr = '0;
    logic [7:0]  code_rdata = '0;
    logic        code_rd_en, vfy_valid, ext_fetch_block, prog_inhibit;
    logic        vfy_inhibit, ext_sel_mismatch;
    logic [7:0]  vfy_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [7:0] exp_key [32];

    always #5 clk = ~clk;

    cpl_guard u_dut (
        .clk(clk), .rst_n(rst_n), .erase_n(erase_n),
        .key_wr_en(key_wr_en), .key_wr_idx(key_wr_idx), .key_wr_data(key_wr_data),
        .lock1_set(lock1_set), .lock2_set(lock2_set), .ext_sel_pin(ext_sel_pin),
        .vfy_req(vfy_req), .vfy_addr(vfy_addr), .code_rdata(code_rdata),
        .code_rd_en(code_rd_en), .vfy_valid(vfy_valid), .vfy_data(vfy_data),
        .ext_fetch_block(ext_fetch_block), .prog_inhibit(prog_inhibit),
        .vfy_inhibit(vfy_inhibit), .ext_sel_mismatch(ext_sel_mismatch)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_flags(input logic [2:0] exp, input string req);
        logic [2:0] act;
        act = {ext_fetch_block, prog_inhibit, vfy_inhibit};
        check(act == exp, req, 16'(act), 16'(exp));
    endtask

    // One verify read; returns the sampled data after the register stage.
    task automatic verify(input logic [15:0] a, input logic [7:0] c,
                          output logic v, output logic [7:0] d, output logic rd);
        @(negedge clk);
        vfy_req = 1'b1; vfy_addr = a; code_rdata = c;
        #1 rd = code_rd_en;
        @(negedge clk);
        vfy_req = 1'b0;
        v = vfy_valid; d = vfy_data;
    endtask

    task automatic check_verify(input logic [15:0] a, input logic [7:0] c,
                                input string req);
        logic v, rd;
        logic [7:0] d, e;
        e = ~(c ^ exp_key[a[4:0]]);
        verify(a, c, v, d, rd);
        check(v == 1'b1, req, 16'(v), 16'd1);
        check(d == e, req, 16'(d), 16'(e));
    endtask

    task automatic write_key(input int i, input logic [7:0] val, input bit lands);
        @(negedge clk);
        key_wr_en = 1'b1; key_wr_idx = 5'(i); key_wr_data = val;
        @(negedge clk);
        key_wr_en = 1'b0;
        if (lands) exp_key[i] = val;
    endtask

    task automatic do_erase();
        @(negedge clk); erase_n = 1'b0;
        @(negedge clk); erase_n = 1'b1;
        for (int i = 0; i < 32; i++) exp_key[i] = 8'hFF;
    endtask

    task automatic pulse(input bit which2);
        @(negedge clk);
        if (which2) lock2_set = 1'b1; else lock1_set = 1'b1;
        @(negedge clk);
        lock1_set = 1'b0; lock2_set = 1'b0;
    endtask

    task automatic program_all_keys();
        for (int i = 0; i < 32; i++) write_key(i, 8'h3C ^ 8'(i * 7), 1'b1);
    endtask

    task automatic t_reset_erase();
        repeat (2) @(negedge clk);
        for (int i = 0; i < 32; i++) exp_key[i] = 8'hFF;
        erase_n = 1'b1;
        @(negedge clk);
        check(vfy_valid == 1'b0, "R2 reset valid", 16'(vfy_valid), 16'd0);
        check_flags(3'b000, "R1 flags after erase");
        rst_n = 1'b1;
        @(negedge clk);
        check_verify(16'h0005, 8'hA7, "R1 erased key passthrough");
        check_verify(16'h001F, 8'h00, "R1 erased key passthrough");
        @(negedge clk);
        check(vfy_valid == 1'b0, "R2 no request no valid", 16'(vfy_valid), 16'd0);
    endtask

    task automatic t_keys_and_wrap();
        program_all_keys();
        check_verify(16'h0000, 8'h5A, "R4 key 0");
        check_verify(16'h0011, 8'hC3, "R4 key 17");
        check_verify(16'h001F, 8'hFF, "R3 key 31");
        check_verify(16'h0020, 8'h12, "R3 wrap to key 0");
        check_verify(16'h1FE3, 8'h80, "R3 high address key 3");
        write_key(3, 8'h00, 1'b1);
        check_verify(16'h0003, 8'h6E, "R4 rewritten key 3");
    endtask

    task automatic t_reserved();
        logic v, rd;
        logic [7:0] d;
        pulse(1'b1);
        check_flags(3'b000, "R6 reserved flags");
        write_key(9, 8'h81, 1'b1);
        check_verify(16'h0009, 8'h4D, "R6 key write in reserved");
        verify(16'h0002, 8'h11, v, d, rd);
        check(rd == 1'b1, "R6 memory read allowed", 16'(rd), 16'd1);
    endtask

    task automatic t_lock1();
        do_erase();
        check_flags(3'b000, "R1 erase clears reserved lock");
        program_all_keys();
        pulse(1'b0);
        check_flags(3'b110, "R5 lock1 flags");
        write_key(6, 8'h00, 1'b0);
        check_verify(16'h0006, 8'h99, "R7 key write ignored");
        check_verify(16'h0026, 8'h3B, "R7 verify keeps scrambling");
    endtask

    task automatic t_sel_latch();
        @(negedge clk); ext_sel_pin = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        check(ext_sel_mismatch == 1'b0, "R10 masked in reset", 16'(ext_sel_mismatch), 16'd0);
        @(negedge clk); rst_n = 1'b1;
        #1 check(ext_sel_mismatch == 1'b0, "R10 match after reset", 16'(ext_sel_mismatch), 16'd0);
        ext_sel_pin = 1'b0;
        #1 check(ext_sel_mismatch == 1'b1, "R10 mismatch raised", 16'(ext_sel_mismatch), 16'd1);
        ext_sel_pin = 1'b1;
        #1 check(ext_sel_mismatch == 1'b0, "R10 mismatch cleared", 16'(ext_sel_mismatch), 16'd0);
    endtask

    task automatic t_full_and_sticky();
        logic v, rd;
        logic [7:0] d;
        pulse(1'b1);
        check_flags(3'b111, "R5 full lock flags");
        verify(16'h0004, 8'h24, v, d, rd);
        check(rd == 1'b0, "R8 no memory read", 16'(rd), 16'd0);
        check(v == 1'b1, "R8 valid while inhibited", 16'(v), 16'd1);
        check(d == 8'hFF, "R8 blank data", 16'(d), 16'hFF);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check_flags(3'b111, "R9 locks survive reset");
        do_erase();
        check_flags(3'b000, "R1 erase clears locks");
        write_key(1, 8'h0F, 1'b1);
        check_verify(16'h0001, 8'hF0, "R9 keys writable after erase");
        check_verify(16'h0002, 8'h3C, "R1 erased key byte");
        ext_sel_pin = 1'b0;
        #1 check(ext_sel_mismatch == 1'b0, "R10 no flag with lock clear", 16'(ext_sel_mismatch), 16'd0);
    endtask

    initial begin
        t_reset_erase();
        t_keys_and_wrap();
        t_reserved();
        t_lock1();
        t_sel_latch();
        t_full_and_sticky();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule